// File: doc/BRIEF.md
# Lockable EEPROM Timebase Prescaler

The block turns a reference clock enable into a periodic single-cycle strobe. Memory program and erase timers use the strobe as their timebase. An 11-bit divisor sets how many reference enables make one interval. Software picks a divisor that gives an interval of roughly 35 µs.

The divisor sits in two byte-wide working registers on a small register bus. Bits 10 to 8 of the divisor share the upper register with an active-low security bit. Writes are refused while an external latch-control flag is raised, and also once security has been switched on. Security freezes both working registers, the security bit included, so software cannot turn it off again.

Each working register has a non-volatile shadow copy, modelled here as a plain register with program and erase request ports. Reset reloads the working registers from the shadow copies. While security is on, the shadow copies refuse all requests and report each refusal.

Top module: `lockable_prescaler`

## Requirements
- R1: While `rst_n` is low, at each clock edge the working registers load from the shadow copies: the security bit from shadow-high bit 7, divisor bits 10..8 from shadow-high bits 2..0, and divisor bits 7..0 from shadow-low. The same edges clear the counter, `tick` and `nv_err`, and shadow requests are ignored. The shadow copies power up as `NV_HI_INIT` (default 8'h80) and `NV_LO_INIT` (default 8'h05).
- R2: `rd_data` is combinational and valid at any time. With `reg_sel`=1 it reads {security, 4'b0000, divisor[10:8]}. With `reg_sel`=0 it reads divisor[7:0].
- R3: A write (`wr_en`=1) is accepted when `latch_active`=0 and the security bit is 1. It updates the register chosen by `reg_sel` at that edge. In the upper register, `wr_data[7]` becomes the security bit and `wr_data[2:0]` become divisor bits 10..8. `wr_data[6:3]` are ignored.
- R4: A write made while `latch_active`=1 is dropped, and both registers keep their values.
- R5: After a write puts 0 into the security bit, every later write to either register is dropped, the security bit included, until the next reset.
- R6: For a divisor D of 2 or more, `tick` is high for exactly one cycle, in the cycle after every D-th clock edge sampled with `ref_en`=1. Counting begins after reset or after an accepted write.
- R7: For a divisor of 0 or 1, `tick` is high in the cycle after every edge sampled with `ref_en`=1.
- R8: An accepted write restarts the counter from zero and forces `tick` low in the next cycle, even if `ref_en` is high at the same edge. The first `tick` then follows the D-th later enable.
- R9: A shadow request takes effect at the clock edge, on the copy chosen by `nv_sel` (1 = high, 0 = low). Erase sets every implemented bit to 1, so shadow-high becomes 8'h87 and shadow-low 8'hFF. Program ANDs `nv_data` into the copy. When `nv_prog` and `nv_erase` are both high, erase wins.
- R10: A shadow request made while the security bit is 0 leaves both copies unchanged. `nv_err` is then high for exactly the next cycle, and `nv_err` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, reloads from shadow |
| ref_en | input | 1 | One pulse per reference clock period |
| reg_sel | input | 1 | Register select: 1 upper, 0 lower |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| latch_active | input | 1 | Latch-control flag, blocks writes when high |
| nv_sel | input | 1 | Shadow select: 1 high copy, 0 low copy |
| nv_prog | input | 1 | Shadow program request |
| nv_erase | input | 1 | Shadow erase request |
| nv_data | input | 8 | Shadow program data |
| nv_err | output | 1 | One-cycle flag for a refused shadow request |
| tick | output | 1 | Timebase strobe |

## Verification
An accepted divisor write can land on the same edge at which the counter would wrap. R8 requires the write to win, so the edge produces no tick and the new interval starts from zero. This collision is forced once on purpose: a write arrives while `ref_en` is held high, and the tick positions after it are checked. A pseudo-random phase adds many more collisions, mixing enables with writes that the latch flag sometimes blocks. A behavioural model decides every cycle of `tick` and `rd_data` in that phase.

// File: rtl/lockable_prescaler.sv
module lockable_prescaler #(
  parameter int DIV_W = 11,
  parameter logic [7:0] NV_HI_INIT = 8'h80,
  parameter logic [7:0] NV_LO_INIT = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       latch_active,
  input  logic       nv_sel,
  input  logic       nv_prog,
  input  logic       nv_erase,
  input  logic [7:0] nv_data,
  output logic       nv_err,
  output logic       tick
);
  localparam int HI_W = DIV_W - 8;
  localparam logic [7:0] HI_MASK = 8'h80 | ((8'd1 << HI_W) - 8'd1);

  logic             sec_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             err_q;
  logic [7:0]       nv_hi_q = NV_HI_INIT & HI_MASK;
  logic [7:0]       nv_lo_q = NV_LO_INIT;

  wire wr_ok  = wr_en & ~latch_active & sec_q;
  wire nv_req = nv_prog | nv_erase;
  wire wrap   = (div_q <= DIV_W'(1)) | (cnt_q >= div_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= nv_hi_q[7];
      div_q <= {nv_hi_q[HI_W-1:0], nv_lo_q};
    end else if (wr_ok) begin
      if (reg_sel) begin
        sec_q            <= wr_data[7];
        div_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
      end else begin
        div_q[7:0] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wr_ok) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (ref_en) begin
      cnt_q  <= wrap ? '0 : cnt_q + DIV_W'(1);
      tick_q <= wrap;
    end else begin
      tick_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= nv_req & ~sec_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && nv_req && sec_q) begin
      if (nv_sel) nv_hi_q <= nv_erase ? HI_MASK : (nv_hi_q & nv_data & HI_MASK);
      else        nv_lo_q <= nv_erase ? 8'hFF   : (nv_lo_q & nv_data);
    end
  end

  assign rd_data = reg_sel ? {sec_q, {(7-HI_W){1'b0}}, div_q[DIV_W-1:8]} : div_q[7:0];
  assign tick    = tick_q;
  assign nv_err  = err_q;
endmodule

// File: rtl/prescaler_chk.sv
module prescaler_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_en,
  input logic             wr_en,
  input logic             latch_active,
  input logic             nv_prog,
  input logic             nv_erase,
  input logic             sec_q,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] cnt_q,
  input logic             tick_q,
  input logic             err_q,
  input logic [7:0]       nv_hi_q,
  input logic [7:0]       nv_lo_q
);
  p_blocked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && latch_active) |=> ($stable(div_q) && $stable(sec_q)));

  p_locked_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_q |=> (!sec_q && $stable(div_q)));

  p_tick_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(ref_en));

  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q > DIV_W'(1)) |-> (cnt_q < div_q));

  p_write_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !latch_active && sec_q) |=> (cnt_q == '0 && !tick_q));

  p_nv_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((nv_prog || nv_erase) && !sec_q) |=> (err_q && $stable(nv_hi_q) && $stable(nv_lo_q)));

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past((nv_prog || nv_erase) && !sec_q));
endmodule

bind lockable_prescaler prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
  .latch_active(latch_active), .nv_prog(nv_prog), .nv_erase(nv_erase),
  .sec_q(sec_q), .div_q(div_q), .cnt_q(cnt_q), .tick_q(tick_q),
  .err_q(err_q), .nv_hi_q(nv_hi_q), .nv_lo_q(nv_lo_q)
);

// File: tb/sim_lockable_prescaler.sv
`timescale 1ns/1ps
module sim_lockable_prescaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0, reg_sel = 1'b0, wr_en = 1'b0, latch_active = 1'b0;
  logic [7:0] wr_data = 8'h00, nv_data = 8'h00;
  logic nv_sel = 1'b0, nv_prog = 1'b0, nv_erase = 1'b0;
  logic [7:0] rd_data;
  logic nv_err, tick;

  int n_chk = 0, n_err = 0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  lockable_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .latch_active(latch_active), .nv_sel(nv_sel), .nv_prog(nv_prog),
    .nv_erase(nv_erase), .nv_data(nv_data), .nv_err(nv_err), .tick(tick)
  );

  int m_sec, m_div, m_cnt, m_tick, m_err;
  int m_nvhi = 'h80, m_nvlo = 'h05;

  always @(posedge clk) begin
    int old_sec;
    started = 1'b1;
    if (!rst_n) begin
      m_sec = (m_nvhi >> 7) & 1;
      m_div = ((m_nvhi & 7) << 8) | m_nvlo;
      m_cnt = 0; m_tick = 0; m_err = 0;
    end else begin
      old_sec = m_sec;
      m_err = 0;
      if (nv_prog || nv_erase) begin
        if (old_sec == 0) m_err = 1;
        else if (nv_erase) begin
          if (nv_sel) m_nvhi = 'h87; else m_nvlo = 'hFF;
        end else begin
          if (nv_sel) m_nvhi = m_nvhi & nv_data & 'h87; else m_nvlo = m_nvlo & nv_data;
        end
      end
      if (wr_en && !latch_active && old_sec == 1) begin
        if (reg_sel) begin
          m_sec = wr_data[7];
          m_div = (m_div & 'hFF) | (int'(wr_data[2:0]) << 8);
        end else begin
          m_div = (m_div & 'h700) | int'(wr_data);
        end
        m_cnt = 0; m_tick = 0;
      end else if (ref_en) begin
        if (m_div <= 1 || m_cnt >= m_div - 1) begin m_cnt = 0; m_tick = 1; end
        else begin m_cnt = m_cnt + 1; m_tick = 0; end
      end else begin
        m_tick = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd;
    #1;
    if (started) begin
      exp_rd = reg_sel ? ((m_sec << 7) | (m_div >> 8)) : (m_div & 'hFF);
      chk("R6 tick vs model", int'(tick), m_tick);
      chk("R10 nv_err vs model", int'(nv_err), m_err);
      chk("R2 rd_data vs model", int'(rd_data), exp_rd);
    end
  end

  task automatic idle();
    wr_en = 1'b0; latch_active = 1'b0; nv_prog = 1'b0; nv_erase = 1'b0;
  endtask

  task automatic rd(input logic s, input int exp, input string tag);
    @(negedge clk); idle(); reg_sel = s; #2;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic wr(input logic s, input logic [7:0] d, input logic lt);
    @(negedge clk); reg_sel = s; wr_data = d; latch_active = lt; wr_en = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic nvop(input logic s, input logic pg, input logic er, input logic [7:0] d);
    @(negedge clk); nv_sel = s; nv_prog = pg; nv_erase = er; nv_data = d;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ref_en = 1'b0; idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (2) @(negedge clk);
    rd(1'b1, 'h80, "R1 reset reload upper");
    rd(1'b0, 'h05, "R1 reset reload lower");
    #1 chk("R1 reset tick low", int'(tick), 0);
    chk("R1 reset err low", int'(nv_err), 0);

    @(negedge clk); rst_n = 1'b1; ref_en = 1'b1; reg_sel = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); #2;
      chk("R6 tick on fifth enable", int'(tick), (i == 5) ? 1 : 0);
    end
    ref_en = 1'b0;

    wr(1'b0, 8'h2C, 1'b0);
    rd(1'b0, 'h2C, "R3 lower write");
    wr(1'b1, 8'hFB, 1'b0);
    rd(1'b1, 'h83, "R3 upper write, bits 6..3 ignored");
    wr(1'b0, 8'h11, 1'b1);
    rd(1'b0, 'h2C, "R4 latch blocks lower write");
    wr(1'b1, 8'h00, 1'b1);
    rd(1'b1, 'h83, "R4 latch blocks upper write");
    wr(1'b1, 8'h80, 1'b0);

    for (int dv = 0; dv <= 1; dv++) begin
      wr(1'b0, 8'(dv), 1'b0);
      @(negedge clk); ref_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #2;
        chk("R7 tick every enable", int'(tick), 1);
      end
      ref_en = 1'b0;
    end

    wr(1'b0, 8'h03, 1'b0);
    @(negedge clk); ref_en = 1'b1;
    repeat (4) @(negedge clk);
    reg_sel = 1'b0; wr_data = 8'h03; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; #2;
    chk("R8 no tick at write edge", int'(tick), 0);
    @(negedge clk); #2 chk("R8 restart +1", int'(tick), 0);
    @(negedge clk); #2 chk("R8 restart +2", int'(tick), 0);
    @(negedge clk); #2 chk("R8 tick at third enable", int'(tick), 1);
    ref_en = 1'b0;

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ref_en = lfsr[0] | lfsr[5];
      reg_sel = 1'b0;
      wr_en = (lfsr[9:6] == 4'd0);
      wr_data = {4'h0, lfsr[13:10]};
      latch_active = lfsr[14];
    end
    @(negedge clk); idle(); ref_en = 1'b0;

    nvop(1'b0, 1'b0, 1'b1, 8'h00);
    nvop(1'b0, 1'b1, 1'b0, 8'h0A);
    nvop(1'b1, 1'b1, 1'b1, 8'h00);
    nvop(1'b1, 1'b1, 1'b0, 8'h82);
    @(negedge clk); rst_n = 1'b0;
    nv_sel = 1'b0; nv_prog = 1'b1; nv_data = 8'h00;
    @(negedge clk); idle();
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, 'h0A, "R9 erase then program lower; R1 request in reset ignored");
    rd(1'b1, 'h82, "R9 erase wins over program upper");

    wr(1'b1, 8'h01, 1'b0);
    rd(1'b1, 'h01, "R5 security enabled by write");
    wr(1'b1, 8'h85, 1'b0);
    rd(1'b1, 'h01, "R5 upper frozen");
    wr(1'b0, 8'h33, 1'b0);
    rd(1'b0, 'h0A, "R5 lower frozen");
    @(negedge clk); nv_sel = 1'b0; nv_erase = 1'b1;
    @(negedge clk); idle(); #2;
    chk("R10 err raised on refused request", int'(nv_err), 1);
    @(negedge clk); #2;
    chk("R10 err lasts one cycle", int'(nv_err), 0);
    do_reset();
    rd(1'b0, 'h0A, "R10 shadow lower unchanged");
    rd(1'b1, 'h82, "R1 security reloaded from shadow");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule